// File: doc/BRIEF.md
# Receive Sample Conditioner

This block sits between a serial audio port's deserialiser and the stereo DAC paths and conditions each received sample pair before playback. It picks the source for the right playback channel (the received left word or the received right word), applies a digital boost of 0, 6, 12 or 18 dB with saturation, and can invert the polarity of each playback channel on its own. The same stage also carries the outgoing (ADC-side) left and right samples, each with its own polarity invert. Boost and source selection do not touch these samples.

All samples are signed two's-complement words of a parameterised width (`W`, 24 bits by default). A single strobe marks a valid set of input words. The result is registered once, and a valid flag delayed by the same cycle comes with it. The control inputs are quasi-static. They are normally tied by configuration logic, and the right-source input is normally held at 1 (right data to right channel).

Top module: `audio_rx_cond`

## Requirements
- R1: With `right_src_sel` = 0 the right playback output is derived from `rx_left_in`. With `right_src_sel` = 1 it is derived from `rx_right_in`. The left playback output always comes from `rx_left_in`.
- R2: `boost_sel` scales both playback samples by a power of two: 2'b00 gives ×1 (0 dB), 2'b01 gives ×2 (+6 dB), 2'b10 gives ×4 (+12 dB) and 2'b11 gives ×8 (+18 dB). The intended input levels for the three boosted settings are below -6, -12 and -18 dBFS.
- R3: A boosted value above 2^(W-1)-1 becomes 2^(W-1)-1. A boosted value below -2^(W-1) becomes -2^(W-1). It never wraps.
- R4: `rx_left_inv` and `rx_right_inv` each negate only their own playback channel when 1, and pass it unchanged when 0.
- R5: `tx_left_inv` and `tx_right_inv` each negate only their own outgoing sample when 1. Outgoing samples are never boosted or re-routed.
- R6: Negating the most negative code -2^(W-1) gives the most positive code 2^(W-1)-1 on any channel.
- R7: The operations run in the order source select, then boost, then invert. For example, a boosted value that saturates to the most negative code comes out as the most positive code when its channel is inverted.
- R8: Outputs change exactly one clock after a cycle with `in_valid` = 1, and `out_valid` equals `in_valid` delayed by one clock. After a cycle with `in_valid` = 0 all four sample outputs hold their values.
- R9: While `rst` is high at a clock edge, `out_valid` and all four sample outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample set valid strobe |
| rx_left_in | input | W | Received left sample (signed) |
| rx_right_in | input | W | Received right sample (signed) |
| tx_left_in | input | W | Outgoing left sample (signed) |
| tx_right_in | input | W | Outgoing right sample (signed) |
| right_src_sel | input | 1 | Right playback source: 0 = left data, 1 = right data |
| boost_sel | input | 2 | Playback boost code, 6 dB per step |
| rx_left_inv | input | 1 | Invert left playback channel |
| rx_right_inv | input | 1 | Invert right playback channel |
| tx_left_inv | input | 1 | Invert outgoing left sample |
| tx_right_inv | input | 1 | Invert outgoing right sample |
| out_valid | output | 1 | Registered valid, one clock after `in_valid` |
| rx_left_out | output | W | Conditioned left playback sample |
| rx_right_out | output | W | Conditioned right playback sample |
| tx_left_out | output | W | Conditioned outgoing left sample |
| tx_right_out | output | W | Conditioned outgoing right sample |

## Verification
The boost is tried with small positive and negative words under each code, which shows whether the shift amount matches the code. It is also tried with words just inside and just outside each code's headroom, which shows a saturating result apart from a wrapped one. Distinct left and right values, with the source select toggled, show whether the right output follows the intended channel. Single invert bits set one at a time show whether the channels are independent, and the tx words confirm that boost never reaches them. The most negative code, with inversion both alone and after a saturating boost, shows both that negation saturates and that boost comes before invert. Idle cycles carrying changed input words show that the outputs hold.

// File: rtl/audcond_pkg.sv
package audcond_pkg;

    // Playback boost code, one step per 6 dB (shift by one bit)
    typedef enum logic [1:0] {
        BOOST_0DB  = 2'b00,
        BOOST_6DB  = 2'b01,
        BOOST_12DB = 2'b10,
        BOOST_18DB = 2'b11
    } boost_e;

    localparam int unsigned MAX_SHIFT = 3;
    localparam int unsigned SHIFT_W   = $clog2(MAX_SHIFT + 1);
    localparam int unsigned NUM_CH    = 4;

    // Channel indices used by the polarity stage
    localparam int unsigned CH_RX_L = 0;
    localparam int unsigned CH_RX_R = 1;
    localparam int unsigned CH_TX_L = 2;
    localparam int unsigned CH_TX_R = 3;

    typedef struct packed {
        logic tx_r;
        logic tx_l;
        logic rx_r;
        logic rx_l;
    } inv_ctrl_t;

    function automatic logic [SHIFT_W-1:0] boost_shift(input boost_e code);
        case (code)
            BOOST_6DB:  return SHIFT_W'(1);
            BOOST_12DB: return SHIFT_W'(2);
            BOOST_18DB: return SHIFT_W'(3);
            default:    return SHIFT_W'(0);
        endcase
    endfunction

    function automatic logic [NUM_CH-1:0] inv_vec(input inv_ctrl_t c);
        logic [NUM_CH-1:0] v;
        v          = '0;
        v[CH_RX_L] = c.rx_l;
        v[CH_RX_R] = c.rx_r;
        v[CH_TX_L] = c.tx_l;
        v[CH_TX_R] = c.tx_r;
        return v;
    endfunction

endpackage

// File: rtl/rxcond_select.sv
module rxcond_select #(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] left_in,
    input  logic [W-1:0] right_in,
    input  logic         right_src_sel,
    output logic [W-1:0] left_out,
    output logic [W-1:0] right_out
);
    always_comb begin
        left_out  = left_in;
        right_out = right_src_sel ? right_in : left_in;
    end
endmodule

// File: rtl/rxcond_gain.sv
module rxcond_gain #(
    parameter int unsigned W     = 24,
    parameter int unsigned SH_MAX = 3,
    parameter int unsigned SH_W   = 2
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] shamt,
    output logic [W-1:0]    dout
);
    localparam int unsigned WW = W + SH_MAX;
    localparam logic signed [WW-1:0] HI =
        $signed({{(SH_MAX+1){1'b0}}, {(W-1){1'b1}}});
    localparam logic signed [WW-1:0] LO =
        $signed({{(SH_MAX+1){1'b1}}, {(W-1){1'b0}}});

    logic signed [WW-1:0] ext;
    logic signed [WW-1:0] shd;

    always_comb begin
        ext = $signed({{SH_MAX{din[W-1]}}, din});
        shd = ext <<< shamt;
        if (shd > HI)
            dout = HI[W-1:0];
        else if (shd < LO)
            dout = LO[W-1:0];
        else
            dout = shd[W-1:0];
    end
endmodule

// File: rtl/rxcond_negate.sv
module rxcond_negate #(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] din,
    input  logic         inv,
    output logic [W-1:0] dout
);
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        if (!inv)
            dout = din;
        else if (din == MINV)
            dout = MAXV;
        else
            dout = -din;
    end
endmodule

// File: rtl/audio_rx_cond.sv
module audio_rx_cond
    import audcond_pkg::*;
#(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] rx_left_in,
    input  logic [W-1:0] rx_right_in,
    input  logic [W-1:0] tx_left_in,
    input  logic [W-1:0] tx_right_in,
    input  logic         right_src_sel,
    input  logic [1:0]   boost_sel,
    input  logic         rx_left_inv,
    input  logic         rx_right_inv,
    input  logic         tx_left_inv,
    input  logic         tx_right_inv,
    output logic         out_valid,
    output logic [W-1:0] rx_left_out,
    output logic [W-1:0] rx_right_out,
    output logic [W-1:0] tx_left_out,
    output logic [W-1:0] tx_right_out
);
    logic [W-1:0] sel_l, sel_r;
    logic [1:0][W-1:0] gain_in, gain_out;
    logic [NUM_CH-1:0][W-1:0] pol_in, pol_out;
    logic [NUM_CH-1:0][W-1:0] out_q;
    logic [SHIFT_W-1:0] shamt;
    logic [NUM_CH-1:0]  invv;
    inv_ctrl_t          inv_c;
    logic               valid_q;

    // Stage 1: source select
    rxcond_select #(.W(W)) u_sel (
        .left_in       (rx_left_in),
        .right_in      (rx_right_in),
        .right_src_sel (right_src_sel),
        .left_out      (sel_l),
        .right_out     (sel_r)
    );

    // Stage 2: saturating boost on the playback pair
    assign shamt      = boost_shift(boost_e'(boost_sel));
    assign gain_in[0] = sel_l;
    assign gain_in[1] = sel_r;

    for (genvar g = 0; g < 2; g++) begin : g_gain
        rxcond_gain #(.W(W), .SH_MAX(MAX_SHIFT), .SH_W(SHIFT_W)) u_gain (
            .din   (gain_in[g]),
            .shamt (shamt),
            .dout  (gain_out[g])
        );
    end

    // Stage 3: per-channel saturating polarity invert
    assign inv_c = '{tx_r: tx_right_inv, tx_l: tx_left_inv,
                     rx_r: rx_right_inv, rx_l: rx_left_inv};
    assign invv  = inv_vec(inv_c);

    always_comb begin
        pol_in[CH_RX_L] = gain_out[0];
        pol_in[CH_RX_R] = gain_out[1];
        pol_in[CH_TX_L] = tx_left_in;
        pol_in[CH_TX_R] = tx_right_in;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_pol
        rxcond_negate #(.W(W)) u_neg (
            .din  (pol_in[c]),
            .inv  (invv[c]),
            .dout (pol_out[c])
        );
    end

    // Output register, loaded on valid samples only
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid)
                out_q <= pol_out;
        end
    end

    assign out_valid    = valid_q;
    assign rx_left_out  = out_q[CH_RX_L];
    assign rx_right_out = out_q[CH_RX_R];
    assign tx_left_out  = out_q[CH_TX_L];
    assign tx_right_out = out_q[CH_TX_R];

endmodule

// File: rtl/audio_rx_cond_chk.sv
module audio_rx_cond_chk #(
    parameter int unsigned W = 24
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] rx_left_in,
    input logic [W-1:0] rx_right_in,
    input logic [W-1:0] tx_left_in,
    input logic [W-1:0] tx_right_in,
    input logic         right_src_sel,
    input logic [1:0]   boost_sel,
    input logic         rx_left_inv,
    input logic         rx_right_inv,
    input logic         tx_left_inv,
    input logic         tx_right_inv,
    input logic         out_valid,
    input logic [W-1:0] rx_left_out,
    input logic [W-1:0] rx_right_out,
    input logic [W-1:0] tx_left_out,
    input logic [W-1:0] tx_right_out
);
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drops_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_on_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(rx_left_out) && $stable(rx_right_out)
                       && $stable(tx_left_out) && $stable(tx_right_out)));

    assert_right_from_left_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !right_src_sel && boost_sel == 2'b00 && !rx_right_inv)
        |=> rx_right_out == $past(rx_left_in));

    assert_tx_passthrough_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !tx_left_inv && !tx_right_inv)
        |=> (tx_left_out == $past(tx_left_in) && tx_right_out == $past(tx_right_in)));

    // R6: an inverted channel can never produce the most negative code
    assert_no_min_after_invert_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rx_left_inv && tx_right_inv)
        |=> (rx_left_out != MINV && tx_right_out != MINV));

endmodule

bind audio_rx_cond audio_rx_cond_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .rx_left_in    (rx_left_in),
    .rx_right_in   (rx_right_in),
    .tx_left_in    (tx_left_in),
    .tx_right_in   (tx_right_in),
    .right_src_sel (right_src_sel),
    .boost_sel     (boost_sel),
    .rx_left_inv   (rx_left_inv),
    .rx_right_inv  (rx_right_inv),
    .tx_left_inv   (tx_left_inv),
    .tx_right_inv  (tx_right_inv),
    .out_valid     (out_valid),
    .rx_left_out   (rx_left_out),
    .rx_right_out  (rx_right_out),
    .tx_left_out   (tx_left_out),
    .tx_right_out  (tx_right_out)
);

// File: tb/test_audio_rx_cond.sv
module test_audio_rx_cond;
    localparam int    W          = 24;
    localparam time   CLK_PERIOD = 10ns;
    localparam longint MAXV = (longint'(1) <<< (W-1)) - 1;
    localparam longint MINV = -(longint'(1) <<< (W-1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [W-1:0] rx_left_in = '0, rx_right_in = '0, tx_left_in = '0, tx_right_in = '0;
    logic right_src_sel = 1'b1;
    logic [1:0] boost_sel = 2'b00;
    logic rx_left_inv = 1'b0, rx_right_inv = 1'b0, tx_left_inv = 1'b0, tx_right_inv = 1'b0;
    logic out_valid;
    logic [W-1:0] rx_left_out, rx_right_out, tx_left_out, tx_right_out;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // reference state: what the outputs should show after the next edge
    longint e_rl = 0, e_rr = 0, e_tl = 0, e_tr = 0;
    bit     e_v  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_rx_cond #(.W(W)) i_audio_rx_cond (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .rx_left_in(rx_left_in), .rx_right_in(rx_right_in),
        .tx_left_in(tx_left_in), .tx_right_in(tx_right_in),
        .right_src_sel(right_src_sel), .boost_sel(boost_sel),
        .rx_left_inv(rx_left_inv), .rx_right_inv(rx_right_inv),
        .tx_left_inv(tx_left_inv), .tx_right_inv(tx_right_inv),
        .out_valid(out_valid),
        .rx_left_out(rx_left_out), .rx_right_out(rx_right_out),
        .tx_left_out(tx_left_out), .tx_right_out(tx_right_out)
    );

    function automatic longint clampw(input longint x);
        if (x > MAXV) return MAXV;
        if (x < MINV) return MINV;
        return x;
    endfunction

    function automatic longint m_boost(input longint x, input logic [1:0] code);
        longint mult;
        case (code)
            2'b01:   mult = 2;
            2'b10:   mult = 4;
            2'b11:   mult = 8;
            default: mult = 1;
        endcase
        return clampw(x * mult);
    endfunction

    function automatic longint m_inv(input longint x, input bit inv);
        return inv ? clampw(-x) : x;
    endfunction

    function automatic longint sx(input logic [W-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic chk(input string tag, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "out_valid", longint'(out_valid), longint'(e_v));
        chk(tag, "rx_left_out", sx(rx_left_out), e_rl);
        chk(tag, "rx_right_out", sx(rx_right_out), e_rr);
        chk(tag, "tx_left_out", sx(tx_left_out), e_tl);
        chk(tag, "tx_right_out", sx(tx_right_out), e_tr);
    endtask

    // Drive at a falling edge, update the model, compare at the next falling edge
    task automatic step(input bit v, input longint rl, input longint rr,
                        input longint tl, input longint tr, input bit src,
                        input logic [1:0] bc, input bit irl, input bit irr,
                        input bit itl, input bit itr, input string tag);
        in_valid = v;
        rx_left_in = W'(rl); rx_right_in = W'(rr);
        tx_left_in = W'(tl); tx_right_in = W'(tr);
        right_src_sel = src; boost_sel = bc;
        rx_left_inv = irl; rx_right_inv = irr; tx_left_inv = itl; tx_right_inv = itr;
        if (v) begin
            e_rl = m_inv(m_boost(rl, bc), irl);
            e_rr = m_inv(m_boost(src ? rr : rl, bc), irr);
            e_tl = m_inv(tl, itl);
            e_tr = m_inv(tr, itr);
        end
        e_v = v;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state, with live inputs present
        in_valid = 1'b1; rx_left_in = 24'h123456;
        repeat (3) @(negedge clk);
        compare("R9");
        rst = 1'b0;

        // R1: pass-through and source select
        step(1, 1000, -2000, 300, -400, 1, 2'b00, 0,0,0,0, "R1");
        step(1, 1000, -2000, 300, -400, 0, 2'b00, 0,0,0,0, "R1");
        step(1, -77, 5555, 1, 2, 0, 2'b00, 0,0,0,0, "R1");
        // R2: each boost code, both signs
        step(1, 1000, -3000, 11, 12, 1, 2'b01, 0,0,0,0, "R2");
        step(1, -1000, 3000, 11, 12, 1, 2'b10, 0,0,0,0, "R2");
        step(1, 12345, -54321, 11, 12, 1, 2'b11, 0,0,0,0, "R2");
        step(1, 12345, -54321, 11, 12, 0, 2'b11, 0,0,0,0, "R2");
        // R3: edges of headroom per code
        step(1, MAXV/2, MINV/2, 0, 0, 1, 2'b01, 0,0,0,0, "R3");
        step(1, MAXV/2 + 1, MINV/2 - 1, 0, 0, 1, 2'b01, 0,0,0,0, "R3");
        step(1, MAXV/4 + 1, MINV/4 - 1, 0, 0, 1, 2'b10, 0,0,0,0, "R3");
        step(1, MAXV, MINV, 0, 0, 1, 2'b11, 0,0,0,0, "R3");
        step(1, MAXV/8, MINV/8, 0, 0, 1, 2'b11, 0,0,0,0, "R3");
        // R4: independent playback invert
        step(1, 500, 600, 7, 8, 1, 2'b00, 1,0,0,0, "R4");
        step(1, 500, 600, 7, 8, 1, 2'b00, 0,1,0,0, "R4");
        step(1, -500, 600, 7, 8, 1, 2'b01, 1,1,0,0, "R4");
        // R5: tx invert, tx untouched by boost/select
        step(1, 1, 2, 4000, -5000, 0, 2'b11, 0,0,1,0, "R5");
        step(1, 1, 2, 4000, -5000, 0, 2'b11, 0,0,0,1, "R5");
        step(1, 1, 2, MAXV, MINV + 1, 1, 2'b10, 0,0,1,1, "R5");
        // R6: most negative code inverted
        step(1, MINV, MINV, MINV, MINV, 1, 2'b00, 1,1,1,1, "R6");
        // R7: boost saturates first, then invert
        step(1, MINV/2 - 5, MAXV/2 + 5, 0, 0, 1, 2'b01, 1,1,0,0, "R7");
        step(1, -3, MINV, 0, 0, 0, 2'b11, 1,1,0,0, "R7");
        // R8: idle cycles with changed data hold outputs
        step(0, 99, 98, 97, 96, 0, 2'b10, 1,1,1,1, "R8");
        step(0, -9, -8, -7, -6, 1, 2'b00, 0,0,0,0, "R8");
        step(1, 42, 43, 44, 45, 1, 2'b00, 0,0,0,0, "R8");
        step(0, 0, 0, 0, 0, 1, 2'b00, 0,0,0,0, "R8");
        // R9: reset in mid-stream
        in_valid = 1'b1; rst = 1'b1;
        e_rl = 0; e_rr = 0; e_tl = 0; e_tr = 0; e_v = 0;
        @(negedge clk);
        compare("R9");
        rst = 1'b0;
        step(1, 7, 8, 9, 10, 1, 2'b00, 0,0,0,0, "R8");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule